// File: doc/BRIEF.md
# Quad-Channel TDM PCM Serial Port

This block carries 8-bit PCM samples for four voice channels between per-channel parallel byte registers and a single serial time-division highway. The highway bit clock is the block clock. Transmit bits change on the rising edge, and received bits are sampled on the falling edge. Both directions send the most significant (sign) bit first. The block does not drive a tri-state pad directly. It produces a data bit and an output enable, and the pad ring builds the high-impedance driver from them. An active-low slot indicator marks every bit period in which the block drives the highway.

Two framing schemes are selected by a mode pin:

- **Independent mode.** Each channel has its own transmit and receive frame strobe and occupies its own slot. All channels share one sync format, either one-bit (short) strobes or wide (long) strobes.
- **Chained mode.** A single short strobe on channel 0 starts a 32-bit burst that carries channels 0 to 3 back to back. The block raises one-bit carry strobes during the final bit of the burst, so that a second device on the same highway can start its own burst directly after this one.

A per-channel power-down mask silences a channel's slot and discards the bytes it would have received. The slot timing still runs while a channel is powered down.

Top module: `tdm4_pcm_port`

## Requirements
- R1: While reset is asserted and after it is released:
  - `tx_oe` is low and `slot_n` is high.
  - Both carry strobes are low.
  - Every `rx_valid` bit is low and every `rx_byte` lane reads zero.
- R2: Short-sync transmit, independent mode (`mode_wide`=0, `sync_long`=0). A channel strobe sampled high on a falling edge starts the slot at the next rising edge. That edge and the 7 rising edges after it drive the byte MSB first on `tx_bit` with `tx_oe` high. The 9th rising edge drops `tx_oe`.
- R3: Short-sync receive. A receive strobe sampled high on a falling edge makes the next 8 falling edges capture `rx_bit`, MSB first. After the 8th capture, `rx_byte` lane k (bits k*8+7..k*8) holds the byte and `rx_valid[k]` is high for exactly one clock cycle.
- R4: Long-sync (`sync_long`=1, independent mode). The transmit slot starts at the first rising edge at which the strobe is high after being low. The receive sign bit is captured on the falling edge that follows that rising edge. A strobe held high for several bit periods starts only one slot.
- R5: Chained mode (`mode_wide`=1):
  - A short strobe on channel 0 starts 32 consecutive bits in each direction, carrying channels 0, 1, 2 and 3 in that order.
  - Strobes on channels 1 to 3 have no effect.
  - `sync_long` has no effect.
- R6: In chained mode, `carry_tx` is high for exactly the bit period in which the 32nd transmit bit is driven. `carry_rx` is high for the bit period that ends with the 32nd receive capture. In independent mode both carry strobes stay low.
- R7: Power-down. A channel whose `pdn` bit is high at the start of its slot keeps `tx_oe` low for that slot. Its received byte is discarded: `rx_valid` stays low and `rx_byte` keeps its previous value.
- R8: In chained mode, the carry strobes are generated with unchanged timing even when all four `pdn` bits are high.
- R9: `slot_n` is low in exactly those bit periods in which some powered-up channel drives its transmit slot, and high otherwise.
- R10: The transmit byte is taken from `tx_byte` lane k at the rising edge that starts channel k's slot. Changes to that lane afterwards do not alter the bits sent in that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Highway bit clock; transmit on rising edge, receive on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wide | input | 1 | 0: independent 8-bit slots; 1: chained 32-bit burst |
| sync_long | input | 1 | Sync format in independent mode: 0 short, 1 long |
| pdn | input | NCH | Per-channel power-down, high = down |
| fs_tx | input | NCH | Per-channel transmit frame strobes |
| fs_rx | input | NCH | Per-channel receive frame strobes |
| tx_byte | input | NCH*W | Transmit bytes, lane k at bits k*W+W-1..k*W |
| rx_bit | input | 1 | Serial receive data from the highway |
| tx_bit | output | 1 | Serial transmit data value |
| tx_oe | output | 1 | Transmit output enable; low means the pad is high impedance |
| slot_n | output | 1 | Active-low indicator of an occupied transmit slot |
| carry_tx | output | 1 | Transmit carry strobe for a chained device |
| carry_rx | output | 1 | Receive carry strobe for a chained device |
| rx_byte | output | NCH*W | Last valid received bytes, lane k at bits k*W+W-1..k*W |
| rx_valid | output | NCH | One-cycle pulse per channel when a new byte lands |

## Verification
The assertions rely on four assumptions about the inputs:
- Strobes are spaced so that at most one channel drives the highway at a time.
- A strobe never restarts a slot that is still running.
- `pdn` is steady across the rising edge that opens a slot.
- The mode pin changes only while the highway is idle.

The bench meets these assumptions by running one frame at a time. It sets the mode, format, power-down mask and strobes only at the start of a frame. It clears every strobe and leaves idle bit periods before the next frame. While a chained frame runs, it toggles the strobes of channels 1 to 3 and `sync_long` at random, because the design must ignore them.

// File: rtl/tdm_pcm_pkg.sv
package tdm_pcm_pkg;

   typedef enum logic {
      FMT_SHORT = 1'b0,
      FMT_LONG  = 1'b1
   } sync_fmt_e;

   typedef enum logic {
      MODE_SLOT8 = 1'b0,
      MODE_CHAIN = 1'b1
   } frame_mode_e;

endpackage

// File: rtl/tdm_pcm_tx_lane.sv
// One transmit lane: loads a byte at slot start, shifts it out MSB first on
// rising edges for W bit periods.
module tdm_pcm_tx_lane #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         pd,
   input  logic [W-1:0] din,
   output logic         bit_o,
   output logic         oe_o,
   output logic         last_o
);
   localparam int CW = $clog2(W + 1);

   logic [CW-1:0] cnt;
   logic [W-1:0]  sh;
   logic          off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sh  <= '0;
         off <= 1'b1;
      end else if (start) begin
         cnt <= CW'(W);
         sh  <= din;
         off <= pd;
      end else if (cnt != '0) begin
         cnt <= cnt - CW'(1);
         sh  <= {sh[W-2:0], 1'b0};
      end
   end

   assign bit_o  = sh[W-1];
   assign oe_o   = (cnt != '0) && !off;
   assign last_o = (cnt == CW'(1));
endmodule

// File: rtl/tdm_pcm_rx_lane.sv
// One receive lane: captures W bits MSB first on falling edges, publishes
// the byte with a one-cycle valid unless the lane was powered down.
module tdm_pcm_rx_lane #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         arm,
   input  logic         first,
   input  logic         pd,
   input  logic         din,
   output logic [W-1:0] data_o,
   output logic         valid_o,
   output logic         last_o
);
   localparam int CW = $clog2(W + 1);

   logic [CW-1:0] rcnt;
   logic [W-1:0]  sh;
   logic          off;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rcnt    <= '0;
         sh      <= '0;
         off     <= 1'b1;
         data_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (first) begin
            sh   <= {sh[W-2:0], din};
            rcnt <= CW'(W - 1);
            off  <= pd;
         end else if (arm) begin
            rcnt <= CW'(W);
            off  <= pd;
         end else if (rcnt != '0) begin
            sh   <= {sh[W-2:0], din};
            rcnt <= rcnt - CW'(1);
            if (rcnt == CW'(1) && !off) begin
               data_o  <= {sh[W-2:0], din};
               valid_o <= 1'b1;
            end
         end
      end
   end

   assign last_o = (rcnt == CW'(1));
endmodule

// File: rtl/tdm4_pcm_port.sv
module tdm4_pcm_port
   import tdm_pcm_pkg::*;
#(
   parameter int NCH = 4,
   parameter int W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_wide,
   input  logic             sync_long,
   input  logic [NCH-1:0]   pdn,
   input  logic [NCH-1:0]   fs_tx,
   input  logic [NCH-1:0]   fs_rx,
   input  logic [NCH*W-1:0] tx_byte,
   input  logic             rx_bit,
   output logic             tx_bit,
   output logic             tx_oe,
   output logic             slot_n,
   output logic             carry_tx,
   output logic             carry_rx,
   output logic [NCH*W-1:0] rx_byte,
   output logic [NCH-1:0]   rx_valid
);
   if (NCH < 1) begin : g_bad_nch
      $error("NCH must be at least 1");
   end
   if (W < 2) begin : g_bad_w
      $error("W must be at least 2");
   end

   frame_mode_e mode;
   sync_fmt_e   fmt;
   logic        chain, fmt_long;

   assign mode     = frame_mode_e'(mode_wide);
   assign fmt      = sync_fmt_e'(sync_long);
   assign chain    = (mode == MODE_CHAIN);
   assign fmt_long = (fmt == FMT_LONG) && !chain;   // chained mode is short-sync only (R5)

   logic [NCH-1:0] ftx_nq, ftx_pq, frx_pq, frx_rise;
   logic [NCH-1:0] tx_start, rx_arm, rx_first;
   logic [NCH-1:0] lane_bit, lane_oe, tx_last, rx_last;

   // Short-sync strobe as seen on a falling edge.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) ftx_nq <= '0;
      else        ftx_nq <= fs_tx;
   end

   // Long-sync rise detection on rising edges.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ftx_pq   <= '0;
         frx_pq   <= '0;
         frx_rise <= '0;
      end else begin
         ftx_pq   <= fs_tx;
         frx_pq   <= fs_rx;
         frx_rise <= fs_rx & ~frx_pq;
      end
   end

   for (genvar k = 0; k < NCH; k++) begin : g_ch
      logic own_tx_start, own_rx_arm;
      assign own_tx_start = fmt_long ? (fs_tx[k] & ~ftx_pq[k]) : ftx_nq[k];
      assign own_rx_arm   = !fmt_long & fs_rx[k];
      assign rx_first[k]  = fmt_long & frx_rise[k];

      if (k == 0) begin : g_head
         assign tx_start[k] = own_tx_start;
         assign rx_arm[k]   = own_rx_arm;
      end else begin : g_tail
         // In chained mode each lane opens as its predecessor finishes.
         assign tx_start[k] = chain ? tx_last[k-1] : own_tx_start;
         assign rx_arm[k]   = chain ? rx_last[k-1] : own_rx_arm;
      end

      tdm_pcm_tx_lane #(.W(W)) u_tx (
         .clk    (clk),
         .rst_n  (rst_n),
         .start  (tx_start[k]),
         .pd     (pdn[k]),
         .din    (tx_byte[k*W +: W]),
         .bit_o  (lane_bit[k]),
         .oe_o   (lane_oe[k]),
         .last_o (tx_last[k])
      );

      tdm_pcm_rx_lane #(.W(W)) u_rx (
         .clk     (clk),
         .rst_n   (rst_n),
         .arm     (rx_arm[k]),
         .first   (rx_first[k]),
         .pd      (pdn[k]),
         .din     (rx_bit),
         .data_o  (rx_byte[k*W +: W]),
         .valid_o (rx_valid[k]),
         .last_o  (rx_last[k])
      );
   end

   assign tx_oe    = |lane_oe;
   assign tx_bit   = |(lane_bit & lane_oe);
   assign slot_n   = ~tx_oe;
   assign carry_tx = chain & tx_last[NCH-1];
   assign carry_rx = chain & rx_last[NCH-1];
endmodule

// File: rtl/tdm4_pcm_port_chk.sv
module tdm4_pcm_port_chk #(
   parameter int NCH = 4,
   parameter int W   = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           mode_wide,
   input logic [NCH-1:0] pdn,
   input logic [NCH-1:0] lane_oe,
   input logic           carry_tx,
   input logic           carry_rx,
   input logic [NCH-1:0] rx_valid
);
   localparam int RW = $clog2(W + 2) + 1;

   // R9: at most one lane owns the highway in any bit period.
   p_one_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lane_oe));

   // R6: carry strobes are one bit period wide.
   p_carry_tx_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
      carry_tx |=> !carry_tx);
   p_carry_rx_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
      carry_rx |=> !carry_rx);

   // R6: no carry outside chained mode.
   p_carry_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (carry_tx || carry_rx) |-> mode_wide);

   for (genvar k = 0; k < NCH; k++) begin : g_lane
      logic [RW-1:0] run;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  run <= '0;
         else if (!lane_oe[k])        run <= '0;
         else if (run != {RW{1'b1}})  run <= run + RW'(1);
      end

      // R2: a lane drives for no more than W bit periods in a row.
      p_slot_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
         run <= RW'(W));

      // R3: the received-byte strobe lasts a single cycle.
      p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
         rx_valid[k] |=> !rx_valid[k]);

      // R7: a lane only starts driving if it was powered up at slot start.
      p_pd_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(lane_oe[k]) |-> !$past(pdn[k]));
   end
endmodule

bind tdm4_pcm_port tdm4_pcm_port_chk #(.NCH(NCH), .W(W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_wide (mode_wide),
   .pdn       (pdn),
   .lane_oe   (lane_oe),
   .carry_tx  (carry_tx),
   .carry_rx  (carry_rx),
   .rx_valid  (rx_valid)
);

// File: tb/tdm4_pcm_port_tb_top.sv
module tdm4_pcm_port_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_wide = 1'b0;
   logic        sync_long = 1'b0;
   logic [3:0]  pdn = 4'h0;
   logic [3:0]  fs_tx = 4'h0;
   logic [3:0]  fs_rx = 4'h0;
   logic [31:0] tx_byte = 32'h0;
   logic        rx_bit = 1'b0;
   logic        tx_bit, tx_oe, slot_n, carry_tx, carry_rx;
   logic [31:0] rx_byte;
   logic [3:0]  rx_valid;

   int   n_tests = 0;
   int   n_fail  = 0;
   bit   finished = 1'b0;
   logic [7:0] exp_rx [4];

   always #5 clk = ~clk;

   tdm4_pcm_port #(.NCH(4), .W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .sync_long(sync_long),
      .pdn(pdn), .fs_tx(fs_tx), .fs_rx(fs_rx), .tx_byte(tx_byte), .rx_bit(rx_bit),
      .tx_bit(tx_bit), .tx_oe(tx_oe), .slot_n(slot_n), .carry_tx(carry_tx),
      .carry_rx(carry_rx), .rx_byte(rx_byte), .rx_valid(rx_valid)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic exp_tx_bit(input logic [31:0] b, input int chan, input int i);
      return b[chan*8 + 7 - (i % 8)];
   endfunction

   task automatic run_frame(input bit m32, input bit lng, input int ch,
                            input logic [3:0] pd, input logic [31:0] txb,
                            input logic [31:0] rxb);
      int    n = m32 ? 32 : 8;
      string base  = m32 ? "R5" : (lng ? "R4" : "R2");
      string rbase = m32 ? "R5" : (lng ? "R4" : "R3");
      string ctag  = (m32 && pd == 4'hF) ? "R8" : "R6";
      for (int j = 0; j <= n + 2; j++) begin
         int  i, chan;
         bit  in_slot, eoe;
         @(posedge clk); #1;
         // drive
         if (j == 0) begin
            mode_wide = m32;
            sync_long = m32 ? 1'($urandom % 2) : lng;
            pdn       = pd;
            tx_byte   = txb;
            if (m32) begin
               fs_tx = 4'b0001 | (4'($urandom) & 4'hE);
               fs_rx = 4'b0001 | (4'($urandom) & 4'hE);
            end else begin
               fs_tx = 4'(1 << ch);
               fs_rx = 4'(1 << ch);
            end
         end else if (m32 && j <= n) begin
            fs_tx = 4'($urandom) & 4'hE;   // ignored in chained mode (R5)
            fs_rx = 4'($urandom) & 4'hE;
            if (j % 7 == 0) sync_long = ~sync_long;
         end else if (m32 && j == n + 1) begin
            fs_tx = 4'h0;
            fs_rx = 4'h0;
         end else if (!m32 && j == (lng ? 4 : 1)) begin
            fs_tx = 4'h0;
            fs_rx = 4'h0;
         end
         in_slot = (j >= 1) && (j <= n);
         i    = j - 1;
         chan = in_slot ? (m32 ? i / 8 : ch) : 0;
         rx_bit = in_slot ? rxb[chan*8 + 7 - (i % 8)] : 1'($urandom % 2);
         if (j >= 2 && (j - 2) % 8 == 0 && (j - 2) / 8 < (m32 ? 4 : 1)) begin
            int sc = m32 ? (j - 2) / 8 : ch;
            tx_byte[sc*8 +: 8] = 8'($urandom);   // must not affect the slot (R10)
         end
         #1;
         // check
         eoe = in_slot && !pd[chan];
         chk((in_slot && pd[chan]) ? "R7 tx_oe" : {base, " tx_oe"}, tx_oe, eoe);
         chk("R9 slot_n", slot_n, !eoe);
         if (eoe) chk({base, "/R10 tx_bit"}, tx_bit, exp_tx_bit(txb, chan, i));
         chk({ctag, " carry_tx"}, carry_tx, m32 && j == 32);
         chk({ctag, " carry_rx"}, carry_rx, m32 && j == 32);
         for (int k = 0; k < 4; k++) begin
            bit act = m32 || (k == ch);
            bit ev  = act && !pd[k] && (j == (m32 ? 8*k + 9 : 9));
            string t = (act && pd[k]) ? "R7" : rbase;
            if (ev) exp_rx[k] = rxb[k*8 +: 8];
            chk({t, " rx_valid"}, rx_valid[k], ev);
            chk({t, " rx_byte"}, rx_byte[k*8 +: 8], exp_rx[k]);
         end
      end
   endtask

   initial begin
      void'($urandom(32'h5EED_0C0D));
      for (int k = 0; k < 4; k++) exp_rx[k] = 8'h00;
      repeat (3) @(posedge clk);
      #2;
      // R1: reset state
      chk("R1 tx_oe", tx_oe, 1'b0);
      chk("R1 slot_n", slot_n, 1'b1);
      chk("R1 carry_tx", carry_tx, 1'b0);
      chk("R1 carry_rx", carry_rx, 1'b0);
      chk("R1 rx_valid", rx_valid, 4'h0);
      chk("R1 rx_byte", rx_byte, 32'h0);
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 tx_oe after release", tx_oe, 1'b0);
      chk("R1 rx_valid after release", rx_valid, 4'h0);

      // directed corners
      run_frame(1'b0, 1'b0, 2, 4'h0, 32'hA5C3_96F0, 32'h5A3C_E781);   // R2/R3
      run_frame(1'b0, 1'b1, 1, 4'h0, 32'h0180_7F00, 32'h00C3_8100);   // R4 wide strobe
      run_frame(1'b0, 1'b1, 3, 4'h0, 32'h8100_0000, 32'h7E00_0000);   // R4
      run_frame(1'b1, 1'b0, 0, 4'h0, 32'h1234_ABCD, 32'hFEDC_0135);   // R5/R6
      run_frame(1'b1, 1'b0, 0, 4'hF, 32'hFFFF_FFFF, 32'h0F0F_F0F0);   // R8
      run_frame(1'b1, 1'b0, 0, 4'h2, 32'hC0DE_BEEF, 32'h7171_9393);   // R7 chained
      run_frame(1'b0, 1'b0, 3, 4'h8, 32'hAA00_0000, 32'h5500_0000);   // R7 independent
      run_frame(1'b0, 1'b0, 0, 4'h0, 32'h0000_0080, 32'h0000_0001);   // R2 edge bits

      // constrained random frames
      for (int r = 0; r < 300; r++) begin
         bit         m32 = 1'($urandom % 2);
         bit         lng = m32 ? 1'b0 : 1'($urandom % 2);
         int         ch  = int'($urandom % 4);
         logic [3:0] pd  = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
         run_frame(m32, lng, ch, pd, $urandom, $urandom);
         repeat ($urandom % 3) @(posedge clk);
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion (all requirements)");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule